// File: doc/BRIEF.md
# Video Mode Line and Frame Timing Generator

This block paces the video stream of a serial display link transmitter. Software first loads a small register set while the block is powered down. The vertical region lengths are given in lines. The horizontal durations are given in lane byte clock cycles, not in pixels. Software then sets the power bit. From that point the generator walks every frame through its vertical regions, and every line through its horizontal sections. It raises strobes that downstream packet logic uses to insert sync markers and fetch one pixel packet per active line.

The frame runs in a fixed vertical order: sync lines, back-porch lines, active lines, front-porch lines, and then the next frame. A region programmed with zero lines is left out. Each line starts with a sync marker. In sync-pulse transmission a second marker closes the horizontal sync time. In sync-event and burst transmission there is no closing marker. During active lines a pixel request fires once the horizontal sync and back-porch time has passed. A per-region enable mask tells the link layer where it may drop to low power during blanking.

Top module: `video_timing_gen`

## Requirements
- R1: After reset the power bit and every configuration field are zero. All strobes, `lp_ok`, `pix_window`, `vregion`, `hregion`, `vmode` and `pkt_pixels` read zero.
- R2: Writing bit 0 of address 0 sets the power bit. While that bit is 0, every strobe, `lp_ok`, `pix_window`, `vregion` and `hregion` stay 0. When power is set, the first line of a new frame begins in the cycle right after the write edge.
- R3: A line lasts L lane byte cycles, where L is the value at address 5, or 1 when that value is 0. `line_start` and `sync_start` fire in the first cycle of every line.
- R4: Frame order is sync (`vregion`=0) for the lines at address 6, back porch (1) for the lines at address 7, active (2) for the lines at address 8, and front porch (3) for the lines at address 9, then it repeats. `frame_start` fires together with `line_start` on the first line of each frame.
- R5: A vertical region programmed with 0 lines is skipped. The frame then begins in the first region with a nonzero count.
- R6: On each active line `pix_req` fires exactly once, at line offset S+B. S is the value at address 3 and B is the value at address 4. It fires only if S+B < L. It never fires on other lines.
- R7: The transmission type is in bits [1:0] of address 1: 0 = sync pulses, 1 = sync events, 2 or 3 = burst. With type 0, `sync_end` fires at line offset S on every line when S < L. With any other type it never fires.
- R8: `hregion` gives the horizontal section for the line offset t: 0 when t<S, 1 when t<S+B, 2 when t<S+B+P, and 3 otherwise. P is the pixel count at address 2 (14 bits). `pix_window` is high on active lines while `hregion` is 2.
- R9: The low-power mask is in bits [13:8] of address 1. Bits 0, 1 and 2 allow low power over whole sync, back-porch and front-porch lines. On active lines, bits 3, 4 and 5 allow it in `hregion` 0, 1 and 3. It is never allowed in `hregion` 2 of an active line.
- R10: Writes to addresses 1 through 9 are ignored while the power bit is 1. They take effect when written while it is 0.
- R11: `vmode` and `pkt_pixels` always show the stored transmission type and pixel count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| powered | output | 1 | Power bit state |
| vmode | output | 2 | Stored transmission type |
| pkt_pixels | output | 14 | Stored pixels per packet |
| vregion | output | 2 | Vertical region of the current line |
| hregion | output | 2 | Horizontal section of the current cycle |
| line_start | output | 1 | First cycle of a line |
| frame_start | output | 1 | First cycle of a frame |
| sync_start | output | 1 | Sync start marker request |
| sync_end | output | 1 | Sync end marker request (sync-pulse type only) |
| pix_req | output | 1 | Pixel packet request |
| pix_window | output | 1 | Payload section of an active line |
| lp_ok | output | 1 | Low-power return allowed now |

## Verification
A horizontal counter that is off by one shows up at once as a wrong line period. It also shifts `pix_req` and `sync_end` away from their expected offsets within the first line. A vertical sequencer that is in the wrong state shows up on the next `line_start`, when `vregion` disagrees with the line-by-line order the bench derives from the programmed counts. A missed zero-count skip or a wrong wrap shows up as a wrong line count in the frame, or as a `frame_start` that is late or missing after exactly one frame of cycles. A write lock that leaks shows up as a changed line period while power stays on.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  typedef enum logic [1:0] {
    VR_SYNC  = 2'd0,
    VR_BACK  = 2'd1,
    VR_ACT   = 2'd2,
    VR_FRONT = 2'd3
  } vreg_e;

  typedef enum logic [1:0] {
    HR_SYNC  = 2'd0,
    HR_BACK  = 2'd1,
    HR_PAY   = 2'd2,
    HR_FRONT = 2'd3
  } hreg_e;

  localparam logic [1:0] VT_PULSES = 2'd0;

  localparam int LP_BITS      = 6;
  localparam int LP_FIELD_LSB = 8;

  localparam int A_PWR   = 0;
  localparam int A_MODE  = 1;
  localparam int A_PKT   = 2;
  localparam int A_HSA   = 3;
  localparam int A_HBP   = 4;
  localparam int A_HLINE = 5;
  localparam int A_VSA   = 6;
  localparam int A_VBP   = 7;
  localparam int A_VACT  = 8;
  localparam int A_VFP   = 9;

  // Next region in frame order that has a nonzero count; stays put if none.
  function automatic vreg_e next_vreg(input vreg_e cur, input logic [3:0] nz);
    vreg_e      res;
    logic       found;
    logic [1:0] idx;
    res   = cur;
    found = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      idx = 2'(cur) + 2'(k);
      if (!found && nz[idx]) begin
        res   = vreg_e'(idx);
        found = 1'b1;
      end
    end
    return res;
  endfunction

  // Low-power permission for the current vertical/horizontal position.
  function automatic logic lp_pick(input vreg_e v, input hreg_e h,
                                   input logic [LP_BITS-1:0] en);
    logic r;
    case (v)
      VR_SYNC:  r = en[0];
      VR_BACK:  r = en[1];
      VR_FRONT: r = en[2];
      default: begin
        case (h)
          HR_SYNC:  r = en[3];
          HR_BACK:  r = en[4];
          HR_FRONT: r = en[5];
          default:  r = 1'b0;
        endcase
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int HW     = 15,
  parameter int VW     = 12,
  parameter int PW     = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic                pwr_q,
  output logic [1:0]          vtype_q,
  output logic [LP_BITS-1:0]  lp_en_q,
  output logic [PW-1:0]       pkt_q,
  output logic [HW-1:0]       hsa_q,
  output logic [HW-1:0]       hbp_q,
  output logic [HW-1:0]       hline_q,
  output logic [VW-1:0]       vsa_q,
  output logic [VW-1:0]       vbp_q,
  output logic [VW-1:0]       vact_q,
  output logic [VW-1:0]       vfp_q
);

  logic pwr_wr;
  logic cfg_wr;
  logic unused_wdata;

  assign pwr_wr       = we && (addr == ADDR_W'(A_PWR));
  assign cfg_wr       = we && !pwr_q;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q   <= 1'b0;
      vtype_q <= '0;
      lp_en_q <= '0;
      pkt_q   <= '0;
      hsa_q   <= '0;
      hbp_q   <= '0;
      hline_q <= '0;
      vsa_q   <= '0;
      vbp_q   <= '0;
      vact_q  <= '0;
      vfp_q   <= '0;
    end else if (pwr_wr) begin
      pwr_q <= wdata[0];
    end else if (cfg_wr) begin
      case (addr)
        ADDR_W'(A_MODE): begin
          vtype_q <= wdata[1:0];
          lp_en_q <= wdata[LP_FIELD_LSB +: LP_BITS];
        end
        ADDR_W'(A_PKT):   pkt_q   <= wdata[PW-1:0];
        ADDR_W'(A_HSA):   hsa_q   <= wdata[HW-1:0];
        ADDR_W'(A_HBP):   hbp_q   <= wdata[HW-1:0];
        ADDR_W'(A_HLINE): hline_q <= wdata[HW-1:0];
        ADDR_W'(A_VSA):   vsa_q   <= wdata[VW-1:0];
        ADDR_W'(A_VBP):   vbp_q   <= wdata[VW-1:0];
        ADDR_W'(A_VACT):  vact_q  <= wdata[VW-1:0];
        ADDR_W'(A_VFP):   vfp_q   <= wdata[VW-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/vtg_hcount.sv
module vtg_hcount
  import vtg_pkg::*;
#(
  parameter int HW = 15,
  parameter int PW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [HW-1:0] hsa,
  input  logic [HW-1:0] hbp,
  input  logic [HW-1:0] hline,
  input  logic [PW-1:0] pkt,
  output logic [HW-1:0] line_len,
  output logic          line_end,
  output logic          at_start,
  output logic          at_sync_end,
  output logic          at_req,
  output hreg_e         hreg
);

  localparam int MW = (HW > PW) ? HW : PW;
  localparam int SW = MW + 2;

  function automatic logic [SW-1:0] wide_h(input logic [HW-1:0] v);
    return SW'(v);
  endfunction

  function automatic logic [HW-1:0] eff_len(input logic [HW-1:0] v);
    return (v == '0) ? HW'(1) : v;
  endfunction

  logic [HW-1:0] hcnt_q;
  logic [SW-1:0] t_w;
  logic [SW-1:0] len_w;
  logic [SW-1:0] sync_end_w;
  logic [SW-1:0] bp_end_w;
  logic [SW-1:0] pay_end_w;

  assign line_len   = eff_len(hline);
  assign t_w        = wide_h(hcnt_q);
  assign len_w      = wide_h(line_len);
  assign sync_end_w = wide_h(hsa);
  assign bp_end_w   = wide_h(hsa) + wide_h(hbp);
  assign pay_end_w  = bp_end_w + SW'(pkt);

  assign line_end    = run && (hcnt_q == line_len - HW'(1));
  assign at_start    = run && (hcnt_q == '0);
  assign at_sync_end = run && (t_w == sync_end_w) && (sync_end_w < len_w);
  assign at_req      = run && (t_w == bp_end_w) && (bp_end_w < len_w);

  always_comb begin
    if (t_w < sync_end_w)     hreg = HR_SYNC;
    else if (t_w < bp_end_w)  hreg = HR_BACK;
    else if (t_w < pay_end_w) hreg = HR_PAY;
    else                      hreg = HR_FRONT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hcnt_q <= '0;
    else if (!run)     hcnt_q <= '0;
    else if (line_end) hcnt_q <= '0;
    else               hcnt_q <= hcnt_q + HW'(1);
  end

endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount
  import vtg_pkg::*;
#(
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          line_end,
  input  logic [VW-1:0] vsa,
  input  logic [VW-1:0] vbp,
  input  logic [VW-1:0] vact,
  input  logic [VW-1:0] vfp,
  output vreg_e         vreg,
  output logic          frame_top
);

  localparam int NREG = 4;

  logic [VW-1:0] cnt_arr [NREG];
  logic [NREG-1:0] nz;
  logic [VW-1:0] vcnt_q;
  logic [VW-1:0] cur_cnt;
  logic          region_done;
  vreg_e         first_reg;
  vreg_e         vreg_q;

  assign cnt_arr[0] = vsa;
  assign cnt_arr[1] = vbp;
  assign cnt_arr[2] = vact;
  assign cnt_arr[3] = vfp;

  for (genvar g = 0; g < NREG; g++) begin : g_nz
    assign nz[g] = (cnt_arr[g] != '0);
  end

  assign first_reg   = next_vreg(VR_FRONT, nz);
  assign cur_cnt     = cnt_arr[vreg_q];
  assign region_done = ({1'b0, vcnt_q} + (VW+1)'(1)) >= {1'b0, cur_cnt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vreg_q <= VR_SYNC;
      vcnt_q <= '0;
    end else if (!run) begin
      vreg_q <= first_reg;
      vcnt_q <= '0;
    end else if (line_end) begin
      if (region_done) begin
        vreg_q <= next_vreg(vreg_q, nz);
        vcnt_q <= '0;
      end else begin
        vcnt_q <= vcnt_q + VW'(1);
      end
    end
  end

  assign vreg      = vreg_q;
  assign frame_top = (vreg_q == first_reg) && (vcnt_q == '0);

endmodule

// File: rtl/video_timing_gen.sv
module video_timing_gen
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int HW     = 15,
  parameter int VW     = 12,
  parameter int PW     = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              powered,
  output logic [1:0]        vmode,
  output logic [PW-1:0]     pkt_pixels,
  output logic [1:0]        vregion,
  output logic [1:0]        hregion,
  output logic              line_start,
  output logic              frame_start,
  output logic              sync_start,
  output logic              sync_end,
  output logic              pix_req,
  output logic              pix_window,
  output logic              lp_ok
);

  logic               pwr_w;
  logic [1:0]         vtype_w;
  logic [LP_BITS-1:0] lp_en_w;
  logic [PW-1:0]      pkt_w;
  logic [HW-1:0]      hsa_w, hbp_w, hline_w;
  logic [VW-1:0]      vsa_w, vbp_w, vact_w, vfp_w;

  logic [HW-1:0]      line_len_w;
  logic               line_end_w;
  logic               at_start_w;
  logic               at_sync_end_w;
  logic               at_req_w;
  hreg_e              hreg_w;
  vreg_e              vreg_w;
  logic               frame_top_w;
  logic               active_line_w;

  vtg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HW(HW), .VW(VW), .PW(PW)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .pwr_q   (pwr_w),
    .vtype_q (vtype_w),
    .lp_en_q (lp_en_w),
    .pkt_q   (pkt_w),
    .hsa_q   (hsa_w),
    .hbp_q   (hbp_w),
    .hline_q (hline_w),
    .vsa_q   (vsa_w),
    .vbp_q   (vbp_w),
    .vact_q  (vact_w),
    .vfp_q   (vfp_w)
  );

  vtg_hcount #(.HW(HW), .PW(PW)) u_hcnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (pwr_w),
    .hsa         (hsa_w),
    .hbp         (hbp_w),
    .hline       (hline_w),
    .pkt         (pkt_w),
    .line_len    (line_len_w),
    .line_end    (line_end_w),
    .at_start    (at_start_w),
    .at_sync_end (at_sync_end_w),
    .at_req      (at_req_w),
    .hreg        (hreg_w)
  );

  vtg_vcount #(.VW(VW)) u_vcnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (pwr_w),
    .line_end  (line_end_w),
    .vsa       (vsa_w),
    .vbp       (vbp_w),
    .vact      (vact_w),
    .vfp       (vfp_w),
    .vreg      (vreg_w),
    .frame_top (frame_top_w)
  );

  assign active_line_w = pwr_w && (vreg_w == VR_ACT);

  assign powered     = pwr_w;
  assign vmode       = vtype_w;
  assign pkt_pixels  = pkt_w;
  assign vregion     = pwr_w ? 2'(vreg_w) : 2'd0;
  assign hregion     = pwr_w ? 2'(hreg_w) : 2'd0;
  assign line_start  = at_start_w;
  assign frame_start = at_start_w && frame_top_w;
  assign sync_start  = at_start_w;
  assign sync_end    = at_sync_end_w && (vtype_w == VT_PULSES);
  assign pix_req     = at_req_w && active_line_w;
  assign pix_window  = active_line_w && (hreg_w == HR_PAY);
  assign lp_ok       = pwr_w && lp_pick(vreg_w, hreg_w, lp_en_w);

endmodule

// File: rtl/video_timing_gen_chk.sv
module video_timing_gen_chk #(
  parameter int HW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          powered,
  input logic          line_start,
  input logic          frame_start,
  input logic          sync_start,
  input logic          sync_end,
  input logic          pix_req,
  input logic          lp_ok,
  input logic [1:0]    vregion,
  input logic [1:0]    hregion,
  input logic [1:0]    vmode,
  input logic [HW-1:0] line_len_w
);

  logic [HW:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap_q <= '0;
    else if (!powered)   gap_q <= '0;
    else if (line_start) gap_q <= (HW+1)'(1);
    else                 gap_q <= gap_q + (HW+1)'(1);
  end

  AST_QUIET_WHEN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !powered |-> !(line_start || frame_start || sync_start || sync_end || pix_req || lp_ok)); // R2

  AST_LINE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && powered && $past(powered)) |-> (gap_q == {1'b0, line_len_w})); // R3

  AST_FRAME_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start); // R4

  AST_REQ_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |-> (vregion == 2'd2)); // R6

  AST_END_ONLY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_end |-> (vmode == 2'd0)); // R7

  AST_NO_LP_IN_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && vregion == 2'd2 && hregion == 2'd2) |-> !lp_ok); // R9

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && $past(powered)) |-> $stable(line_len_w)); // R10

endmodule

bind video_timing_gen video_timing_gen_chk #(.HW(HW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .powered     (powered),
  .line_start  (line_start),
  .frame_start (frame_start),
  .sync_start  (sync_start),
  .sync_end    (sync_end),
  .pix_req     (pix_req),
  .lp_ok       (lp_ok),
  .vregion     (vregion),
  .hregion     (hregion),
  .vmode       (vmode),
  .line_len_w  (line_len_w)
);

// File: tb/sim_video_timing_gen.sv
`timescale 1ns/1ps
module sim_video_timing_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        powered;
  logic [1:0]  vmode;
  logic [13:0] pkt_pixels;
  logic [1:0]  vregion, hregion;
  logic        line_start, frame_start, sync_start, sync_end;
  logic        pix_req, pix_window, lp_ok;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  video_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .powered(powered), .vmode(vmode),
    .pkt_pixels(pkt_pixels), .vregion(vregion), .hregion(hregion),
    .line_start(line_start), .frame_start(frame_start),
    .sync_start(sync_start), .sync_end(sync_end), .pix_req(pix_req),
    .pix_window(pix_window), .lp_ok(lp_ok)
  );

  // fields: hsa hbp hline vsa vbp vact vfp type pkt | lines cycles pix send
  localparam int NV = 5;
  localparam int VEC [NV][13] = '{
    '{2, 3, 12, 1, 2, 3, 1, 0, 4,  7, 84, 3, 7},
    '{2, 3, 12, 1, 2, 3, 1, 1, 4,  7, 84, 3, 0},
    '{1, 1,  6, 0, 1, 2, 0, 2, 2,  3, 18, 2, 0},
    '{0, 0,  1, 1, 0, 4, 2, 0, 0,  7,  7, 4, 7},
    '{3, 4,  5, 1, 1, 2, 1, 0, 0,  5, 25, 0, 5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 32'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input int hsa, input int hbp, input int hl, input int vsa,
                      input int vbp, input int vact, input int vfp,
                      input int mode, input int pkt);
    cfg(0, 0);
    cfg(3, hsa); cfg(4, hbp); cfg(5, hl);
    cfg(6, vsa); cfg(7, vbp); cfg(8, vact); cfg(9, vfp);
    cfg(1, mode); cfg(2, pkt);
  endtask

  function automatic int exp_vr(input int ln, input int vsa, input int vbp, input int vact);
    if (ln < vsa) return 0;
    if (ln < vsa + vbp) return 1;
    if (ln < vsa + vbp + vact) return 2;
    return 3;
  endfunction

  task automatic measure_gap(output int g);
    int lim;
    lim = 0;
    while (!line_start && lim < 200) begin step(1); lim++; end
    step(1);
    g = 1;
    while (!line_start && g < 200) begin step(1); g++; end
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int g;
    int q;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: reset state
    chk(powered == 0 && vmode == 0 && pkt_pixels == 0, "R1 cfg", int'(powered), 0);
    q = int'(line_start) + int'(frame_start) + int'(sync_start) + int'(sync_end)
      + int'(pix_req) + int'(pix_window) + int'(lp_ok) + int'(vregion) + int'(hregion);
    chk(q == 0, "R1 outputs", q, 0);

    // table-driven frame walk
    for (int e = 0; e < NV; e++) begin
      int hsa, hbp, hl, vsa, vbp, vact, cyc;
      int nl, np, ns, nss, nf, rmis, omis, ln, pos;
      hsa = VEC[e][0]; hbp = VEC[e][1]; hl = VEC[e][2];
      vsa = VEC[e][3]; vbp = VEC[e][4]; vact = VEC[e][5];
      cyc = VEC[e][10];
      load(hsa, hbp, hl, vsa, vbp, vact, VEC[e][6], VEC[e][7], VEC[e][8]);
      cfg(0, 1);
      nl = 0; np = 0; ns = 0; nss = 0; nf = 0; rmis = 0; omis = 0; ln = -1;
      for (int c = 0; c < cyc; c++) begin
        pos = c % hl;
        if (line_start) begin
          nl++; ln++;
          if (int'(vregion) != exp_vr(ln, vsa, vbp, vact)) rmis++;
          if (pos != 0) omis++;
        end
        if (sync_start) nss++;
        if (frame_start) nf++;
        if (pix_req) begin
          np++;
          if (pos != hsa + hbp) omis++;
        end
        if (sync_end) begin
          ns++;
          if (pos != hsa) omis++;
        end
        step(1);
      end
      chk(nl == VEC[e][9], "R3 lines per frame", nl, VEC[e][9]);
      chk(nss == VEC[e][9], "R3 sync_start per frame", nss, VEC[e][9]);
      chk(np == VEC[e][11], "R6 pix_req count", np, VEC[e][11]);
      chk(ns == VEC[e][12], "R7 sync_end count", ns, VEC[e][12]);
      chk(omis == 0, "R6 R7 strobe offsets", omis, 0);
      chk(rmis == 0, (vsa == 0) ? "R5 region order" : "R4 region order", rmis, 0);
      chk(nf == 1 && frame_start == 1'b1, "R4 frame repeat", nf, 1);
    end

    // R11, R8, R9 directed run
    load(2, 3, 12, 1, 2, 3, 1, (17 << 8) | 2, 4);
    chk(vmode == 2 && pkt_pixels == 4, "R11 stored fields", int'(vmode), 2);
    cfg(0, 1);
    chk(frame_start == 1'b1, "R2 start after power", int'(frame_start), 1);
    chk(lp_ok == 1'b1 && hregion == 0, "R9 sync line lp", int'(lp_ok), 1);
    step(12);
    chk(lp_ok == 1'b0 && vregion == 1, "R9 back porch line lp", int'(lp_ok), 0);
    step(26);
    chk(hregion == 1 && lp_ok == 1'b1 && vregion == 2, "R9 active hbp lp", int'(hregion), 1);
    step(3);
    chk(hregion == 2 && pix_window && pix_req && !lp_ok, "R8 payload section", int'(hregion), 2);
    step(4);
    chk(hregion == 3 && !pix_window && !lp_ok, "R8 front section", int'(hregion), 3);

    // R10: write ignored while powered
    cfg(5, 20);
    measure_gap(g);
    chk(g == 12, "R10 locked line length", g, 12);

    // R2: quiet while down
    cfg(0, 0);
    q = 0;
    for (int c = 0; c < 20; c++) begin
      q += int'(line_start) + int'(sync_start) + int'(lp_ok) + int'(pix_req)
         + int'(vregion) + int'(hregion) + int'(frame_start);
      step(1);
    end
    chk(q == 0, "R2 quiet when down", q, 0);

    // R10: write accepted while down
    cfg(5, 20);
    cfg(0, 1);
    chk(frame_start == 1'b1, "R2 restart frame", int'(frame_start), 1);
    measure_gap(g);
    chk(g == 20, "R10 unlocked line length", g, 20);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule